// File: doc/BRIEF.md
# In-Band Interrupt Arbitration Unit

This block is the target-side engine that competes for an in-band interrupt on a shared two-wire bus with an open-drain data line. Local error or alert logic raises an event, and the block keeps it as a pending request. The block then waits until the bus has stayed quiet for a programmed number of clock cycles. After that it waits for the host to issue a start condition.

When the start arrives, the block sends its dynamic address one bit per sample strobe. It pulls the line low for a 0 bit and releases it for a 1 bit. After each bit it compares the line with what it sent. A released bit that reads back low means another device drove a lower address, so the block stops driving and reports a loss. It keeps the request and tries again after the next idle period. If it is still on the line after the last bit, it reports a win and holds in a won state. The request is cleared when the local logic acknowledges the event.

The data phase that follows a win and the physical pad are handled elsewhere. The pad combines `drive_low_o` with the other drivers on the line and returns the result on `sda_i`.

Top module: `ibi_arbiter`

## Requirements
- R1: A high `event_i` at a clock edge sets the pending flag `pend_o` at that edge. The flag stays set until R9 clears it.
- R2: With `pend_o` low, a host start never causes `drive_low_o` to assert.
- R3: The bus counts as idle in a cycle when `scl_i` and `sda_i` are both high and neither changed since the previous cycle. Arbitration is armed only after `idle_cycles_i` idle cycles in a row. Any non-idle cycle restarts the count, and a start seen before the count completes is ignored.
- R4: Once armed, a start condition begins arbitration. A start is `sda_i` falling while `scl_i` stays high. Any other bus activity while armed disarms the unit and the idle count restarts.
- R5: During arbitration the address `dyn_addr_i` is sent MSB first, one bit per `bit_sample_i` pulse. `drive_low_o` is 1 for a 0 bit and 0 for a 1 bit. Outside arbitration `drive_low_o` is 0.
- R6: If a bit that was released samples low on `bit_sample_i`, then at that same clock edge `drive_low_o` goes to 0 and stays there, and `lost_o` pulses high for exactly one cycle.
- R7: If all bits are sampled without a loss, `won_o` pulses high for exactly one cycle after the last sample. The unit then holds with `pend_o` set. A lower address therefore beats a higher one.
- R8: After a loss, `pend_o` stays set and the unit goes back to the idle wait. It retries on the next idle period and start.
- R9: `event_ack_i` clears `pend_o` at the next edge only while the unit holds after a win. At any other time it has no effect.
- R10: In reset, `pend_o`, `drive_low_o`, `won_o` and `lost_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_i | input | 1 | Local event raising an interrupt request |
| event_ack_i | input | 1 | Acknowledge of a won request; clears the pending flag |
| dyn_addr_i | input | ADDR_W | Dynamic address used as the arbitration word |
| idle_cycles_i | input | IDLE_W | Number of idle cycles needed before arbitration is allowed |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Resolved data line as seen at the pad |
| bit_sample_i | input | 1 | Strobe marking the sample point of each arbitration bit |
| drive_low_o | output | 1 | Pull the data line low; otherwise the line is released |
| pend_o | output | 1 | Pending interrupt request |
| won_o | output | 1 | One-cycle pulse: arbitration won |
| lost_o | output | 1 | One-cycle pulse: arbitration lost |

## Verification
The bench places a modelled competitor on the same wired-AND line. The competitor drops out by the same low-wins rule, so the bench exercises address pairs where the block loses at the MSB, at the LSB or somewhere in between. It also covers equal addresses and runs with no competitor.

A design that compares on driven bits, or keeps driving after a mismatch, would report the wrong winner. Such a design would also corrupt the line for the remaining bits.

Directed cases cover the following faults:
- A start that comes before the idle count completes. A timer that does not restart on activity would arbitrate too early.
- Bus activity while armed, immediately followed by a start. A unit that is never disarmed would wrongly accept that start.
- Acknowledges given outside the won state. An ungated acknowledge would lose the request.
- A retry after a loss. Dropping the request on a loss would stop the retry from ever winning.

// File: rtl/ibi_arb_pkg.sv
package ibi_arb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_WAIT_IDLE  = 3'd1,
      ST_WAIT_START = 3'd2,
      ST_ARB        = 3'd3,
      ST_WON        = 3'd4,
      ST_LOST       = 3'd5
   } arb_state_e;

endpackage

// File: rtl/ibi_bus_monitor.sv
// Watches the two bus lines: flags activity (any low or any change) and
// a start condition (data falls while clock stays high).
module ibi_bus_monitor (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic active_o,
   output logic start_o
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign active_o = ~scl_i | ~sda_i | (scl_i ^ scl_q) | (sda_i ^ sda_q);
   assign start_o  = scl_q & scl_i & sda_q & ~sda_i;

endmodule

// File: rtl/ibi_idle_timer.sv
// Saturating idle counter; done once the count has reached the limit.
module ibi_idle_timer #(
   parameter int IDLE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic [IDLE_W-1:0] limit_i,
   output logic              done_o
);

   logic [IDLE_W-1:0] cnt_q;

   assign done_o = (cnt_q >= limit_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (!done_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/ibi_bit_engine.sv
// Holds the arbitration word, selects the current bit, drives it
// open-drain style and compares it with the resolved line.
module ibi_bit_engine #(
   parameter int ADDR_W    = 7,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              step_i,
   input  logic              enable_i,
   input  logic              line_i,
   output logic              drive_low_o,
   output logic              last_o,
   output logic              mismatch_o
);

   localparam int IDX_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_W - 1);

   logic [ADDR_W-1:0] word_q;
   logic [IDX_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  pos;
   logic              cur_bit;

   generate
      if (MSB_FIRST) begin : g_msb_first
         assign pos = LAST_IDX - cnt_q;
      end else begin : g_lsb_first
         assign pos = cnt_q;
      end
   endgenerate

   assign cur_bit     = word_q[pos];
   assign last_o      = (cnt_q == LAST_IDX);
   assign mismatch_o  = cur_bit & ~line_i;
   assign drive_low_o = enable_i & ~cur_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '1;
         cnt_q  <= '0;
      end else if (load_i) begin
         word_q <= addr_i;
         cnt_q  <= '0;
      end else if (step_i && !last_o) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/ibi_arbiter.sv
module ibi_arbiter #(
   parameter int ADDR_W    = 7,
   parameter int IDLE_W    = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              event_i,
   input  logic              event_ack_i,
   input  logic [ADDR_W-1:0] dyn_addr_i,
   input  logic [IDLE_W-1:0] idle_cycles_i,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              bit_sample_i,
   output logic              drive_low_o,
   output logic              pend_o,
   output logic              won_o,
   output logic              lost_o
);

   import ibi_arb_pkg::*;

   generate
      if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr_w
         $error("ibi_arbiter: ADDR_W must be within 1..64");
      end
      if (IDLE_W < 1 || IDLE_W > 32) begin : g_bad_idle_w
         $error("ibi_arbiter: IDLE_W must be within 1..32");
      end
   endgenerate

   arb_state_e state_q;
   arb_state_e state_d;
   logic       pend_q;
   logic       won_q;
   logic       bus_active;
   logic       bus_start;
   logic       idle_done;
   logic       bit_last;
   logic       bit_mismatch;
   logic       in_arb;
   logic       word_load;
   logic       word_step;

   ibi_bus_monitor i_mon (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .active_o (bus_active),
      .start_o  (bus_start)
   );

   ibi_idle_timer #(.IDLE_W(IDLE_W)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i ((state_q != ST_WAIT_IDLE) | bus_active),
      .limit_i (idle_cycles_i),
      .done_o  (idle_done)
   );

   assign in_arb    = (state_q == ST_ARB);
   assign word_load = (state_q == ST_WAIT_START) & bus_start;
   assign word_step = in_arb & bit_sample_i;

   ibi_bit_engine #(.ADDR_W(ADDR_W), .MSB_FIRST(MSB_FIRST)) i_bits (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (word_load),
      .addr_i      (dyn_addr_i),
      .step_i      (word_step),
      .enable_i    (in_arb),
      .line_i      (sda_i),
      .drive_low_o (drive_low_o),
      .last_o      (bit_last),
      .mismatch_o  (bit_mismatch)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:       if (pend_q) state_d = ST_WAIT_IDLE;
         ST_WAIT_IDLE:  if (idle_done && !bus_active) state_d = ST_WAIT_START;
         ST_WAIT_START: begin
            if (bus_start)       state_d = ST_ARB;
            else if (bus_active) state_d = ST_WAIT_IDLE;
         end
         ST_ARB: begin
            if (bit_sample_i) begin
               if (bit_mismatch)  state_d = ST_LOST;
               else if (bit_last) state_d = ST_WON;
            end
         end
         ST_WON:        if (event_ack_i) state_d = ST_IDLE;
         ST_LOST:       state_d = ST_WAIT_IDLE;
         default:       state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= 1'b0;
         won_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         won_q   <= in_arb && (state_d == ST_WON);
         if (event_i) begin
            pend_q <= 1'b1;
         end else if (state_q == ST_WON && event_ack_i) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign pend_o = pend_q;
   assign won_o  = won_q;
   assign lost_o = (state_q == ST_LOST);

endmodule

// File: rtl/ibi_arbiter_chk.sv
module ibi_arbiter_chk
   import ibi_arb_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input arb_state_e state_q,
   input logic       bus_start,
   input logic       drive_low_o,
   input logic       pend_o,
   input logic       won_o,
   input logic       lost_o,
   input logic       event_ack_i,
   input logic       bit_sample_i,
   input logic       sda_i
);

   assert_arb_needs_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ARB) |-> pend_o);

   assert_arb_entry_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ARB && $past(state_q) != ST_ARB) |-> $past(bus_start));

   assert_drive_only_in_arb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      drive_low_o |-> (state_q == ST_ARB));

   assert_drop_on_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ARB && bit_sample_i && !drive_low_o && !sda_i) |=> (lost_o && !drive_low_o));

   assert_lost_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lost_o |=> !lost_o);

   assert_won_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      won_o |=> !won_o);

   assert_won_with_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
      won_o |-> (pend_o && !lost_o));

   assert_retry_after_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lost_o |=> (state_q == ST_WAIT_IDLE && pend_o));

   assert_pend_clear_by_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_o) |-> ($past(event_ack_i) && $past(state_q) == ST_WON));

endmodule

bind ibi_arbiter ibi_arbiter_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .state_q      (state_q),
   .bus_start    (bus_start),
   .drive_low_o  (drive_low_o),
   .pend_o       (pend_o),
   .won_o        (won_o),
   .lost_o       (lost_o),
   .event_ack_i  (event_ack_i),
   .bit_sample_i (bit_sample_i),
   .sda_i        (sda_i)
);

// File: tb/test_ibi_arbiter.sv
`timescale 1ns/1ps
module test_ibi_arbiter;

   localparam int ADDR_W = 7;
   localparam int IDLE_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              event_i = 1'b0;
   logic              event_ack_i = 1'b0;
   logic [ADDR_W-1:0] dyn_addr_i = '0;
   logic [IDLE_W-1:0] idle_cycles_i = 16'd8;
   logic              scl = 1'b1;
   logic              host_sda = 1'b1;
   logic              comp_low = 1'b0;
   logic              bit_sample_i = 1'b0;
   logic              drive_low_o;
   logic              pend_o;
   logic              won_o;
   logic              lost_o;
   logic              sda_line;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   assign sda_line = host_sda & ~comp_low & ~drive_low_o;

   always #2.5 clk = ~clk;

   ibi_arbiter #(.ADDR_W(ADDR_W), .IDLE_W(IDLE_W)) i_ibi_arbiter (
      .clk           (clk),
      .rst_n         (rst_n),
      .event_i       (event_i),
      .event_ack_i   (event_ack_i),
      .dyn_addr_i    (dyn_addr_i),
      .idle_cycles_i (idle_cycles_i),
      .scl_i         (scl),
      .sda_i         (sda_line),
      .bit_sample_i  (bit_sample_i),
      .drive_low_o   (drive_low_o),
      .pend_o        (pend_o),
      .won_o         (won_o),
      .lost_o        (lost_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Expected outcome of the low-wins contest, computed bit by bit.
   function automatic bit exp_loses(input logic [ADDR_W-1:0] mine,
                                    input logic [ADDR_W-1:0] other, input bit has_other);
      bit other_in = has_other;
      for (int b = ADDR_W - 1; b >= 0; b--) begin
         bit line_v = ~((~mine[b]) | (other_in & ~other[b]));
         if (mine[b] && !line_v) return 1'b1;
         if (other_in && other[b] && !line_v) other_in = 1'b0;
      end
      return 1'b0;
   endfunction

   task automatic idle_bus(input int n);
      @(negedge clk);
      scl = 1'b1; host_sda = 1'b1; comp_low = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic host_start;
      @(negedge clk) host_sda = 1'b0;
      @(negedge clk) scl = 1'b0;
      host_sda = 1'b1;
   endtask

   task automatic raise_event;
      @(negedge clk) event_i = 1'b1;
      @(negedge clk) event_i = 1'b0;
      chk("R1 pending set", pend_o, 1);
   endtask

   task automatic pulse_ack;
      @(negedge clk) event_ack_i = 1'b1;
      @(negedge clk) event_ack_i = 1'b0;
   endtask

   task automatic run_arb(input logic [ADDR_W-1:0] mine, input logic [ADDR_W-1:0] other,
                          input bit has_other, output bit lost);
      bit me_in = 1'b1;
      bit other_in = has_other;
      lost = 1'b0;
      for (int b = ADDR_W - 1; b >= 0; b--) begin
         bit exp_drive;
         bit line_v;
         @(negedge clk) comp_low = other_in & ~other[b];
         @(negedge clk);
         exp_drive = me_in & ~mine[b];
         chk("R5 drive level per bit", drive_low_o, exp_drive);
         line_v = ~(exp_drive | comp_low);
         bit_sample_i = 1'b1;
         @(negedge clk) bit_sample_i = 1'b0;
         if (me_in) begin
            if (mine[b] && !line_v) begin
               me_in = 1'b0;
               lost = 1'b1;
               chk("R6 lost pulse", lost_o, 1);
               chk("R6 drive released on loss", drive_low_o, 0);
               @(negedge clk);
               chk("R6 lost pulse single", lost_o, 0);
               chk("R8 pending kept after loss", pend_o, 1);
            end else if (b == 0) begin
               chk("R7 won pulse", won_o, 1);
               chk("R7 no lost on win", lost_o, 0);
            end else begin
               chk("R6 no lost on match", lost_o, 0);
            end
         end
         if (other_in && other[b] && !line_v) other_in = 1'b0;
      end
      @(negedge clk) comp_low = 1'b0;
   endtask

   task automatic finish_win;
      chk("R7 won pulse single", won_o, 0);
      chk("R7 pending held until ack", pend_o, 1);
      pulse_ack;
      chk("R9 ack clears pending", pend_o, 0);
   endtask

   task automatic trial(input logic [ADDR_W-1:0] mine, input logic [ADDR_W-1:0] other,
                        input bit has_other, input int idle_n);
      bit lost;
      dyn_addr_i = mine;
      idle_cycles_i = IDLE_W'(idle_n);
      raise_event;
      pulse_ack;
      chk("R9 ack ignored outside won", pend_o, 1);
      idle_bus(idle_n + 6);
      host_start;
      run_arb(mine, other, has_other, lost);
      chk("R7 outcome matches low-wins", lost, exp_loses(mine, other, has_other));
      if (lost) begin
         idle_bus(idle_n + 6);
         host_start;
         run_arb(mine, '0, 1'b0, lost);
         chk("R8 retry wins alone", lost, 0);
      end
      finish_win;
      idle_bus(2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      bit lost;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      chk("R10 reset pend", pend_o, 0);
      chk("R10 reset drive", drive_low_o, 0);
      chk("R10 reset won", won_o, 0);
      chk("R10 reset lost", lost_o, 0);
      rst_n = 1'b1;

      // R2: no pending request, start and sample strobes must not drive
      dyn_addr_i = 7'h00;
      idle_cycles_i = 16'd4;
      idle_bus(12);
      host_start;
      for (int b = 0; b < ADDR_W; b++) begin
         @(negedge clk) bit_sample_i = 1'b1;
         @(negedge clk) bit_sample_i = 1'b0;
         chk("R2 no drive without pending", drive_low_o, 0);
         chk("R2 no won without pending", won_o, 0);
      end

      // R3: start before the idle count completes is ignored
      dyn_addr_i = 7'h15;
      idle_cycles_i = 16'd20;
      idle_bus(4);
      raise_event;
      idle_bus(10);
      host_start;
      repeat (4) begin
         @(negedge clk);
         chk("R3 early start ignored", drive_low_o, 0);
      end
      @(negedge clk) scl = 1'b1;
      @(negedge clk) host_sda = 1'b1;
      // R4: activity while armed disarms; a start right after is ignored
      idle_bus(26);
      @(negedge clk) scl = 1'b0;
      @(negedge clk) scl = 1'b1;
      host_start;
      repeat (4) begin
         @(negedge clk);
         chk("R4 start after disarm ignored", drive_low_o, 0);
      end
      idle_bus(26);
      host_start;
      run_arb(7'h15, '0, 1'b0, lost);
      chk("R4 armed start wins alone", lost, 0);
      finish_win;

      // Directed contests: loss at MSB, loss at LSB, equal, higher rival
      trial(7'h40, 7'h00, 1'b1, 3);
      trial(7'h21, 7'h20, 1'b1, 1);
      trial(7'h33, 7'h33, 1'b1, 0);
      trial(7'h05, 7'h7F, 1'b1, 2);
      trial(7'h7F, 7'h7E, 1'b1, 5);

      for (int t = 0; t < 30; t++) begin
         logic [ADDR_W-1:0] m = ADDR_W'($urandom);
         logic [ADDR_W-1:0] o = ADDR_W'($urandom);
         bit h = ($urandom % 4) != 0;
         int n = int'($urandom % 24) + 1;
         trial(m, o, h, n);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule